// File: doc/BRIEF.md
# Pin I/O Controller with Event Interrupts

This block gives firmware register-level control over a bank of general-purpose pins. Firmware reads the pin levels, sets the values the pins drive, and chooses pin by pin whether the output driver is on. A small memory-mapped bus carries every access. It has an address, a write strobe, write data, and read data that follows the address within the same cycle.

Each pin can also raise an interrupt. The trigger can be a low level, a high level, a falling edge or a rising edge, and a separate double-edge bit makes any change of level count. Each pin's event is caught in a status bit that stays set until firmware writes a one to it. All status bits are ORed onto a single interrupt line. Every control field has its own set address and clear address. Firmware can therefore change one pin's setting without a read-modify-write.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: Reading offset 0x00 returns the pin inputs after a two-flop synchronizer, so a pin change is visible after two rising clock edges. Writing offset 0x00 loads the output data register.
- R2: Offset 0x04 reads and writes the output data register. `pin_out` always equals that register, and it changes only on a write to 0x00 or 0x04.
- R3: Writing offset 0x10 sets each output-enable bit whose write-data bit is one. Writing offset 0x14 clears each bit whose write-data bit is one. Zero bits change nothing. Reading either address returns the enables, and `pin_oe` equals them.
- R4: Four more fields use the same set/clear scheme. Interrupt enable is at 0x20/0x24, type at 0x28/0x2C, polarity at 0x30/0x34 and double-edge at 0x40/0x44. Reading either address of a pair returns that field.
- R5: With type 0, polarity 0 triggers while the synchronized pin is low, and polarity 1 triggers while it is high.
- R6: With type 1, polarity 0 triggers on a falling edge and polarity 1 on a rising edge. An edge is found by comparing the synchronized sample with the sample from one cycle earlier. The status bit sets on the third rising clock edge after the pin changes.
- R7: When a pin's double-edge bit is one, both rising and falling edges trigger, whatever the type and polarity bits hold.
- R8: A status bit latches an event only while that pin's interrupt enable bit is one. An edge that occurred while the enable was zero is not caught afterwards.
- R9: Offset 0x38 reads the latched status. Writing a one to a bit clears it, and writing a zero leaves it unchanged.
- R10: If an event and a clear of the same status bit fall in the same cycle, the bit stays set. A level trigger whose level is still present therefore cannot be cleared.
- R11: `irq` is the OR of all status bits.
- R12: Every register resets to zero. Read-data bits above the pin count are zero. Unmapped addresses read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register accessed |
| bus_wr | input | 1 | Write strobe, taken on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 16 | Asynchronous pin levels |
| pin_out | output | 16 | Output data driven to the pins |
| pin_oe | output | 16 | Per-pin output driver enable |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is a write-one-to-clear that lands in the same clock cycle as a new edge event on the same pin. The edge enters the status logic only after two synchronizer stages and the previous-sample flop. To reach it, the bench changes the pin on a falling clock edge and waits out exactly two rising edges. It then issues the clear write, so that the write commits on the third rising edge, the same edge that latches the event. A level trigger that is still active gives the same collision on every cycle, and the bench uses it to confirm that such a bit cannot be cleared.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   localparam int N_CTRL = 5;

   typedef enum int {
      CTRL_OE   = 0,
      CTRL_IE   = 1,
      CTRL_TYPE = 2,
      CTRL_POL  = 3,
      CTRL_DBE  = 4
   } ctrl_idx_e;

   localparam logic [7:0] OFF_PINS = 8'h00;
   localparam logic [7:0] OFF_DOUT = 8'h04;
   localparam logic [7:0] OFF_STAT = 8'h38;

   function automatic logic [7:0] ctrl_set_off(input int k);
      case (k)
         CTRL_OE:   return 8'h10;
         CTRL_IE:   return 8'h20;
         CTRL_TYPE: return 8'h28;
         CTRL_POL:  return 8'h30;
         default:   return 8'h40;
      endcase
   endfunction

   function automatic logic [7:0] ctrl_clr_off(input int k);
      return ctrl_set_off(k) + 8'h04;
   endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int WIDTH  = 16,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] raw_i,
   output logic [WIDTH-1:0] smp_o,
   output logic [WIDTH-1:0] prv_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_in_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain_q;
   logic [WIDTH-1:0]             prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= '0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], raw_i};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign smp_o = chain_q[STAGES-1];
   assign prv_o = prev_q;

endmodule

// File: rtl/gpio_setclr_reg.sv
module gpio_setclr_reg #(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] set_i,
   input  logic [WIDTH-1:0] clr_i,
   output logic [WIDTH-1:0] q_o
);

   if (WIDTH < 1) begin : g_bad_width
      $error("gpio_setclr_reg: WIDTH must be positive");
   end

   logic [WIDTH-1:0] q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= (q & ~clr_i) | set_i;
   end

   assign q_o = q;

   AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i == '0 && clr_i == '0) |=> $stable(q)); // R3

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
   parameter int NPIN = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NPIN-1:0] smp_i,
   input  logic [NPIN-1:0] prv_i,
   input  logic [NPIN-1:0] ie_i,
   input  logic [NPIN-1:0] type_i,
   input  logic [NPIN-1:0] pol_i,
   input  logic [NPIN-1:0] dbe_i,
   input  logic [NPIN-1:0] w1c_i,
   output logic [NPIN-1:0] stat_o
);

   logic [NPIN-1:0] evt;
   logic [NPIN-1:0] stat_q;

   for (genvar i = 0; i < NPIN; i++) begin : g_pin
      always_comb begin
         if (dbe_i[i])       evt[i] = smp_i[i] ^ prv_i[i];
         else if (type_i[i]) evt[i] = pol_i[i] ? (smp_i[i] & ~prv_i[i])
                                                : (~smp_i[i] & prv_i[i]);
         else                evt[i] = pol_i[i] ? smp_i[i] : ~smp_i[i];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stat_q[i] <= 1'b0;
         else        stat_q[i] <= (stat_q[i] & ~w1c_i[i]) | (evt[i] & ie_i[i]);
      end

      AST_STAT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(stat_q[i]) |-> $past(ie_i[i])); // R8

      AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         (stat_q[i] && !w1c_i[i]) |=> stat_q[i]); // R9
   end

   assign stat_o = stat_q;

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
   import gpio_irq_pkg::*;
#(
   parameter int NPIN        = 16,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NPIN-1:0]   pin_in,
   output logic [NPIN-1:0]   pin_out,
   output logic [NPIN-1:0]   pin_oe,
   output logic              irq
);

   if (NPIN < 1 || NPIN > DATA_W) begin : g_bad_npin
      $error("gpio_irq_ctrl: NPIN must lie in 1..DATA_W");
   end
   if (ADDR_W < 7) begin : g_bad_addr
      $error("gpio_irq_ctrl: ADDR_W too small for the register map");
   end

   localparam int PAD_W = DATA_W - NPIN;

   logic [NPIN-1:0] wmask;
   logic [NPIN-1:0] smp, prv;
   logic [NPIN-1:0] dout_q;
   logic [NPIN-1:0] stat;
   logic [NPIN-1:0] w1c;
   logic [NPIN-1:0] ctrl_q   [N_CTRL];
   logic [NPIN-1:0] ctrl_set [N_CTRL];
   logic [NPIN-1:0] ctrl_clr [N_CTRL];
   logic            dout_wr;

   assign wmask = bus_wdata[NPIN-1:0];

   gpio_in_sync #(.WIDTH(NPIN), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .raw_i (pin_in),
      .smp_o (smp),
      .prv_o (prv)
   );

   for (genvar k = 0; k < N_CTRL; k++) begin : g_ctrl
      localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(ctrl_set_off(k));
      localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(ctrl_clr_off(k));

      assign ctrl_set[k] = (bus_wr && bus_addr == SET_A) ? wmask : '0;
      assign ctrl_clr[k] = (bus_wr && bus_addr == CLR_A) ? wmask : '0;

      gpio_setclr_reg #(.WIDTH(NPIN)) u_reg (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (ctrl_set[k]),
         .clr_i (ctrl_clr[k]),
         .q_o   (ctrl_q[k])
      );
   end

   assign dout_wr = bus_wr && (bus_addr == ADDR_W'(OFF_PINS) ||
                               bus_addr == ADDR_W'(OFF_DOUT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       dout_q <= '0;
      else if (dout_wr) dout_q <= wmask;
   end

   assign w1c = (bus_wr && bus_addr == ADDR_W'(OFF_STAT)) ? wmask : '0;

   gpio_irq_detect #(.NPIN(NPIN)) u_detect (
      .clk    (clk),
      .rst_n  (rst_n),
      .smp_i  (smp),
      .prv_i  (prv),
      .ie_i   (ctrl_q[CTRL_IE]),
      .type_i (ctrl_q[CTRL_TYPE]),
      .pol_i  (ctrl_q[CTRL_POL]),
      .dbe_i  (ctrl_q[CTRL_DBE]),
      .w1c_i  (w1c),
      .stat_o (stat)
   );

   always_comb begin
      logic [NPIN-1:0] val;
      val = '0;
      if (bus_addr == ADDR_W'(OFF_PINS))      val = smp;
      else if (bus_addr == ADDR_W'(OFF_DOUT)) val = dout_q;
      else if (bus_addr == ADDR_W'(OFF_STAT)) val = stat;
      for (int k = 0; k < N_CTRL; k++) begin
         if (bus_addr == ADDR_W'(ctrl_set_off(k)) ||
             bus_addr == ADDR_W'(ctrl_clr_off(k)))
            val = ctrl_q[k];
      end
      if (PAD_W > 0) bus_rdata = {{PAD_W{1'b0}}, val};
      else           bus_rdata = DATA_W'(val);
   end

   assign pin_out = dout_q;
   assign pin_oe  = ctrl_q[CTRL_OE];
   assign irq     = |stat;

   AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(|ctrl_q[CTRL_IE])); // R11

   AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !dout_wr |=> $stable(pin_out)); // R2

endmodule

// File: tb/tb_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_irq_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [15:0] pins = '0;
   logic [15:0] pin_out, pin_oe;
   logic        irq;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   gpio_irq_ctrl dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pins),
      .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
      logic [31:0] d;
      rd(a, d);
      chk(req, d, exp);
   endtask

   task automatic set_pin(input int idx, input logic v);
      @(negedge clk);
      pins[idx] = v;
      repeat (3) @(posedge clk);
   endtask

   task automatic tidy();
      wr(8'h24, 32'hFFFF);
      wr(8'h2C, 32'hFFFF);
      wr(8'h34, 32'hFFFF);
      wr(8'h44, 32'hFFFF);
      wr(8'h38, 32'hFFFF);
   endtask

   task automatic t_reset();
      rd_chk("R12 pins", 8'h00, 0);
      rd_chk("R12 dout", 8'h04, 0);
      rd_chk("R12 oe", 8'h10, 0);
      rd_chk("R12 ie", 8'h20, 0);
      rd_chk("R12 type", 8'h28, 0);
      rd_chk("R12 pol", 8'h30, 0);
      rd_chk("R12 stat", 8'h38, 0);
      rd_chk("R12 dbe", 8'h40, 0);
      chk("R12 pin_oe", pin_oe, 0);
      chk("R12 pin_out", pin_out, 0);
      chk("R12 irq", irq, 0);
   endtask

   task automatic t_dout();
      wr(8'h00, 32'hA5A5);
      chk("R1 write 0x00 -> pin_out", pin_out, 32'hA5A5);
      rd_chk("R2 read 0x04", 8'h04, 32'hA5A5);
      wr(8'h04, 32'hFFFF_FFFF);
      chk("R2 pin_out", pin_out, 32'hFFFF);
      rd_chk("R12 upper bits zero", 8'h04, 32'h0000_FFFF);
      wr(8'h04, 32'h0F0F);
      chk("R2 pin_out", pin_out, 32'h0F0F);
   endtask

   task automatic t_oe();
      wr(8'h10, 32'h00F0);
      wr(8'h10, 32'h0003);
      rd_chk("R3 set accumulates", 8'h14, 32'h00F3);
      wr(8'h14, 32'h0010);
      rd_chk("R3 clear ones only", 8'h10, 32'h00E3);
      chk("R3 pin_oe", pin_oe, 32'h00E3);
   endtask

   task automatic t_ctrl_rb();
      wr(8'h28, 32'h8001); rd_chk("R4 type", 8'h2C, 32'h8001);
      wr(8'h2C, 32'hFFFF); rd_chk("R4 type clr", 8'h28, 0);
      wr(8'h30, 32'h8001); rd_chk("R4 pol", 8'h34, 32'h8001);
      wr(8'h34, 32'hFFFF); rd_chk("R4 pol clr", 8'h30, 0);
      wr(8'h40, 32'h8001); rd_chk("R4 dbe", 8'h44, 32'h8001);
      wr(8'h44, 32'hFFFF); rd_chk("R4 dbe clr", 8'h40, 0);
      wr(8'h20, 32'h8001); rd_chk("R4 ie", 8'h24, 32'h8001);
      wr(8'h24, 32'hFFFF); rd_chk("R4 ie clr", 8'h20, 0);
      wr(8'h38, 32'hFFFF);
      rd_chk("R9 stat cleared", 8'h38, 0);
   endtask

   task automatic t_pins();
      @(negedge clk);
      pins = 16'h1234;
      @(posedge clk);
      @(negedge clk);
      bus_addr = 8'h00;
      #1 chk("R1 one edge not yet visible", bus_rdata, 0);
      rd_chk("R1 pins after sync", 8'h00, 32'h1234);
      @(negedge clk);
      pins = '0;
      repeat (3) @(posedge clk);
   endtask

   task automatic t_rise();
      wr(8'h28, 32'h1); wr(8'h30, 32'h1); wr(8'h20, 32'h1);
      @(negedge clk);
      pins[0] = 1'b1;
      repeat (2) @(negedge clk);
      chk("R6 not latched before third edge", irq, 0);
      @(negedge clk);
      chk("R6 rising latched on third edge / R11 irq", irq, 1);
      rd_chk("R6 rising status", 8'h38, 32'h1);
      wr(8'h38, 32'h0);
      rd_chk("R9 zero write no effect", 8'h38, 32'h1);
      wr(8'h38, 32'hFFFE);
      rd_chk("R9 other ones no effect", 8'h38, 32'h1);
      wr(8'h38, 32'h1);
      rd_chk("R9 w1c", 8'h38, 0);
      chk("R11 irq low", irq, 0);
      set_pin(0, 1'b0);
      rd_chk("R6 falling ignored in rising mode", 8'h38, 0);
      tidy();
   endtask

   task automatic t_fall();
      wr(8'h28, 32'h2); wr(8'h20, 32'h2);
      set_pin(1, 1'b1);
      rd_chk("R6 rising ignored in falling mode", 8'h38, 0);
      set_pin(1, 1'b0);
      rd_chk("R6 falling status", 8'h38, 32'h2);
      tidy();
   endtask

   task automatic t_level();
      wr(8'h30, 32'h4); wr(8'h20, 32'h4);
      repeat (3) @(posedge clk);
      rd_chk("R5 high level idle", 8'h38, 0);
      set_pin(2, 1'b1);
      rd_chk("R5 high level status", 8'h38, 32'h4);
      wr(8'h38, 32'h4);
      rd_chk("R10 active level survives clear", 8'h38, 32'h4);
      set_pin(2, 1'b0);
      wr(8'h38, 32'h4);
      rd_chk("R10 clear after level gone", 8'h38, 0);
      tidy();
      wr(8'h20, 32'h8);
      rd_chk("R5 low level status", 8'h38, 32'h8);
      set_pin(3, 1'b1);
      wr(8'h38, 32'h8);
      rd_chk("R5 low level gone", 8'h38, 0);
      set_pin(3, 1'b0);
      tidy();
   endtask

   task automatic t_dbe();
      wr(8'h28, 32'h10); wr(8'h30, 32'h10); wr(8'h40, 32'h10); wr(8'h20, 32'h10);
      set_pin(4, 1'b1);
      rd_chk("R7 double edge rise", 8'h38, 32'h10);
      wr(8'h38, 32'h10);
      set_pin(4, 1'b0);
      rd_chk("R7 double edge fall overrides polarity", 8'h38, 32'h10);
      wr(8'h38, 32'h10);
      repeat (3) @(posedge clk);
      rd_chk("R7 no event when stable", 8'h38, 0);
      tidy();
   endtask

   task automatic t_disabled();
      wr(8'h28, 32'h40); wr(8'h30, 32'h40);
      set_pin(6, 1'b1);
      rd_chk("R8 no latch while disabled", 8'h38, 0);
      chk("R8 irq low", irq, 0);
      wr(8'h20, 32'h40);
      repeat (3) @(posedge clk);
      rd_chk("R8 old edge not caught", 8'h38, 0);
      set_pin(6, 1'b0);
      tidy();
   endtask

   task automatic t_collide();
      wr(8'h28, 32'h20); wr(8'h30, 32'h20); wr(8'h20, 32'h20);
      @(negedge clk);
      pins[5] = 1'b1;
      @(negedge clk);
      wr(8'h38, 32'h20);
      rd_chk("R10 set wins over clear", 8'h38, 32'h20);
      wr(8'h38, 32'h20);
      rd_chk("R9 later clear works", 8'h38, 0);
      set_pin(5, 1'b0);
      tidy();
   endtask

   task automatic t_unmapped();
      wr(8'h08, 32'hFFFF);
      rd_chk("R12 unmapped reads zero", 8'h08, 0);
      rd_chk("R12 unmapped write no effect oe", 8'h10, 32'h00E3);
      rd_chk("R12 unmapped write no effect dout", 8'h04, 32'h0F0F);
      rd_chk("R12 unmapped write no effect ie", 8'h20, 0);
   endtask

   initial begin
      #1_000_000;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_dout();
      t_oe();
      t_ctrl_rb();
      t_pins();
      t_rise();
      t_fall();
      t_level();
      t_dbe();
      t_disabled();
      t_collide();
      t_unmapped();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule